// File: doc/BRIEF.md
# Ultra DMA Read Start Sequencer

This host-side block opens an Ultra DMA read burst. On a start request from host logic it captures the transfer mode and the address and chip-select values. It drives those lines and then waits for the device's DMA request, with no time limit. After a setup interval it asserts the acknowledge and releases the host's data-bus drivers. After an envelope interval it drives STOP low and the host-ready signal low. It then waits for the first device strobe transition. When that transition arrives no earlier than the mode's first-strobe time, it hands the burst to a separate receive path.

All intervals are clock counts. They are derived from a clock-period parameter `CLK_NS` and a nanosecond table for modes 0 to 5. Minimums round up and maximums round down. A strobe transition that comes too early raises a sticky error flag. If the device withdraws its request before a valid first strobe, or the receive path hands control back, the block negates acknowledge. It keeps the address lines for one setup interval longer and then returns to idle. `CLK_NS` must lie between 2 and 25 so that the envelope minimum fits under the mode-5 maximum.

Derived counts: ACK = max(ceil(20/CLK_NS),1), ENV = max(ceil(20/CLK_NS),2), FS(m) = ceil(fs_ns(m)/CLK_NS) with fs_ns = 230, 200, 170, 130, 120, 90 ns for modes 0..5. With the default 10 ns clock these give ACK=2, ENV=2 and FS = 23, 20, 17, 13, 12, 9.

Top module: `udma_rd_init`

## Requirements
- R1: While and after reset with no start: dmack_n_o=1, stop_o=1, hdmardy_n_o=1, dd_oe_o=1, da_o=0, cs_n_o all ones, busy_o=0, first_strobe_o=0, err_o=0.
- R2: A start_i sampled in idle captures mode_i, addr_i and cs_n_i. From the next cycle da_o and cs_n_o show the captured values and hold them until idle is re-entered. Later changes to mode_i have no effect on the burst.
- R3: While dmarq_i stays low after a start, dmack_n_o stays high for any number of cycles.
- R4: dmack_n_o goes low exactly ACK+1 cycles after dmarq_i is first driven high, measured at successive sample points.
- R5: dd_oe_o is low in every cycle in which dmack_n_o is low.
- R6: stop_o and hdmardy_n_o fall together exactly ENV cycles after dmack_n_o falls. This is never later than floor(max_env_ns/CLK_NS) cycles, where max_env_ns is 70 ns for modes 0-2, 55 ns for modes 3-4 and 50 ns for mode 5.
- R7: dstrobe_i transitions while dmack_n_o is high set neither err_o nor first_strobe_o.
- R8: A dstrobe_i transition during the cycle k cycles after dmack_n_o fell, with k < FS(mode), sets err_o from the next cycle until the next start. first_strobe_o stays 0 and the wait continues.
- R9: The first dstrobe_i transition with k >= FS(mode) makes first_strobe_o 1 from the next cycle. dmack_n_o, stop_o and hdmardy_n_o stay low while it is 1.
- R10: If dmarq_i is low before a valid first strobe while acknowledge is asserted, then from the next cycle dmack_n_o, stop_o and hdmardy_n_o are high. da_o and cs_n_o hold for ACK cycles, then the block is idle.
- R11: release_i while first_strobe_o is 1 negates acknowledge from the next cycle, holds the address lines for ACK cycles, then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a read burst (sampled in idle) |
| mode_i | input | 3 | Transfer mode 0..5 |
| addr_i | input | AW | Address value to drive during the burst |
| cs_n_i | input | CSW | Chip-select value to drive during the burst |
| dmarq_i | input | 1 | Device DMA request |
| dstrobe_i | input | 1 | Device data strobe |
| release_i | input | 1 | Receive path returns control |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| stop_o | output | 1 | STOP line to device |
| hdmardy_n_o | output | 1 | Host ready, active low |
| dd_oe_o | output | 1 | Host data-bus driver enable |
| da_o | output | AW | Address lines |
| cs_n_o | output | CSW | Chip-select lines |
| busy_o | output | 1 | Sequence in progress |
| first_strobe_o | output | 1 | Valid first strobe seen, burst handed over |
| err_o | output | 1 | Early strobe seen (sticky until next start) |

## Verification
Every output is decoded from the sequencer state, so a wrong state shows at the ports on the cycle after the faulty transition. It appears as an acknowledge or STOP edge one or more cycles off the expected count, or as address lines that move mid-burst. A miscounted first-strobe limit shows up only when a transition lands exactly at FS-1 or FS. The bench therefore places strobe edges on both sides of that boundary in several modes. A wrong early-drop path shows as acknowledge left low after the request falls, or as address lines released before the ACK hold has elapsed.

// File: rtl/udma_rd_init.sv
module udma_rd_init #(
  parameter int CLK_NS = 10,
  parameter int AW     = 3,
  parameter int CSW    = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [2:0]     mode_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CSW-1:0] cs_n_i,
  input  logic           dmarq_i,
  input  logic           dstrobe_i,
  input  logic           release_i,
  output logic           dmack_n_o,
  output logic           stop_o,
  output logic           hdmardy_n_o,
  output logic           dd_oe_o,
  output logic [AW-1:0]  da_o,
  output logic [CSW-1:0] cs_n_o,
  output logic           busy_o,
  output logic           first_strobe_o,
  output logic           err_o
);

  function automatic int cdiv(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int fs_ns(logic [2:0] m);
    case (m)
      3'd0:    return 230;
      3'd1:    return 200;
      3'd2:    return 170;
      3'd3:    return 130;
      3'd4:    return 120;
      default: return 90;
    endcase
  endfunction

  localparam int CNT_W   = $clog2(230 / CLK_NS + 4) + 1;
  localparam int ACK_RAW = cdiv(20);
  localparam int ACK_C   = (ACK_RAW < 1) ? 1 : ACK_RAW;
  localparam int ENV_C   = (ACK_RAW < 2) ? 2 : ACK_RAW;
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_C - 1);
  localparam logic [CNT_W-1:0] ENV_LAST = CNT_W'(ENV_C - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_RQ, S_SETUP, S_ACK, S_ENV, S_WAIT_FS, S_ACTIVE, S_HOLD
  } st_t;

  st_t              st;
  logic [2:0]       mode_q;
  logic [AW-1:0]    addr_q;
  logic [CSW-1:0]   cs_q;
  logic [CNT_W-1:0] cnt;
  logic             ds_q;
  logic             err_q;
  logic [CNT_W-1:0] fs_lim;
  logic             s_edge;
  logic             acked;

  assign fs_lim = CNT_W'(cdiv(fs_ns(mode_q)));
  assign s_edge = dstrobe_i ^ ds_q;
  assign acked  = (st == S_ACK) || (st == S_ENV) || (st == S_WAIT_FS);

  always_ff @(posedge clk) ds_q <= dstrobe_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      mode_q <= '0;
      addr_q <= '0;
      cs_q   <= '1;
      cnt    <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          mode_q <= mode_i;
          addr_q <= addr_i;
          cs_q   <= cs_n_i;
          err_q  <= 1'b0;
          st     <= S_WAIT_RQ;
        end
        S_WAIT_RQ: if (dmarq_i) begin
          cnt <= '0;
          st  <= S_SETUP;
        end
        S_SETUP: begin
          if (!dmarq_i) st <= S_IDLE;
          else if (cnt >= ACK_LAST) begin
            cnt <= '0;
            st  <= S_ACK;
          end else cnt <= cnt + 1'b1;
        end
        S_ACTIVE: if (release_i) begin
          cnt <= '0;
          st  <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt >= ACK_LAST) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: begin
          if (!dmarq_i) begin
            cnt <= '0;
            st  <= S_HOLD;
          end else begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (s_edge && cnt < fs_lim) err_q <= 1'b1;
            if (st == S_ACK) st <= S_ENV;
            else if (st == S_ENV && cnt >= ENV_LAST) st <= S_WAIT_FS;
            else if (st == S_WAIT_FS && s_edge && cnt >= fs_lim) st <= S_ACTIVE;
          end
        end
      endcase
    end
  end

  assign dmack_n_o      = !(acked || st == S_ACTIVE);
  assign stop_o         = !(st == S_WAIT_FS || st == S_ACTIVE);
  assign hdmardy_n_o    = stop_o;
  assign dd_oe_o        = (st == S_IDLE) || (st == S_WAIT_RQ) || (st == S_SETUP);
  assign da_o           = (st == S_IDLE) ? '0 : addr_q;
  assign cs_n_o         = (st == S_IDLE) ? '1 : cs_q;
  assign busy_o         = (st != S_IDLE);
  assign first_strobe_o = (st == S_ACTIVE);
  assign err_o          = err_q;

endmodule

module udma_rd_init_chk #(
  parameter int AW  = 3,
  parameter int CSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           dmarq_i,
  input logic           dmack_n_o,
  input logic           stop_o,
  input logic           hdmardy_n_o,
  input logic           dd_oe_o,
  input logic [AW-1:0]  da_o,
  input logic [CSW-1:0] cs_n_o,
  input logic           busy_o,
  input logic           first_strobe_o,
  input logic           err_o
);

  // R3
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> dmack_n_o);

  // R2
  lines_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(da_o) && $stable(cs_n_o)));

  // R4
  ack_needs_rq_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dmack_n_o) |-> $past(dmarq_i));

  // R5
  bus_released_chk: assert property (@(posedge clk) disable iff (rst)
    !dmack_n_o |-> !dd_oe_o);

  // R6
  stop_rdy_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_o) |-> (!hdmardy_n_o && !dmack_n_o));

  // R7
  err_only_acked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !$past(dmack_n_o));

  // R9
  active_held_chk: assert property (@(posedge clk) disable iff (rst)
    first_strobe_o |-> (!stop_o && !hdmardy_n_o && !dmack_n_o));

  // R10
  ack_drop_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dmack_n_o) |-> (stop_o && hdmardy_n_o && busy_o));

endmodule

bind udma_rd_init udma_rd_init_chk #(.AW(AW), .CSW(CSW)) u_chk (.*);

// File: tb/udma_rd_init_bench.sv
module udma_rd_init_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS = 10;
  localparam int AW = 3;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [CSW-1:0] cs_n_i = '1;
  logic dmarq_i = 1'b0;
  logic dstrobe_i = 1'b0;
  logic release_i = 1'b0;
  logic dmack_n_o, stop_o, hdmardy_n_o, dd_oe_o, busy_o, first_strobe_o, err_o;
  logic [AW-1:0] da_o;
  logic [CSW-1:0] cs_n_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udma_rd_init #(.CLK_NS(CLK_NS), .AW(AW), .CSW(CSW)) u_udma_rd_init (.*);

  function automatic int cd(int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int ack_c(); return (cd(20) < 1) ? 1 : cd(20); endfunction
  function automatic int env_c(); return (cd(20) < 2) ? 2 : cd(20); endfunction
  function automatic int env_hi(int m);
    return ((m <= 2) ? 70 : (m <= 4) ? 55 : 50) / CLK_NS;
  endfunction
  function automatic int fs_c(int m);
    case (m)
      0: return cd(230); 1: return cd(200); 2: return cd(170);
      3: return cd(130); 4: return cd(120); default: return cd(90);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle_chk(string req);
    chk({req, " dmack_n"}, int'(dmack_n_o), 1);
    chk({req, " stop"}, int'(stop_o), 1);
    chk({req, " hdmardy_n"}, int'(hdmardy_n_o), 1);
    chk({req, " dd_oe"}, int'(dd_oe_o), 1);
    chk({req, " da"}, int'(da_o), 0);
    chk({req, " cs_n"}, int'(cs_n_o), (1 << CSW) - 1);
    chk({req, " busy"}, int'(busy_o), 0);
  endtask

  task automatic hold_tail(string req, int a, int c);
    chk({req, " dmack_n after drop"}, int'(dmack_n_o), 1);
    chk({req, " stop after drop"}, int'(stop_o), 1);
    chk({req, " hdmardy_n after drop"}, int'(hdmardy_n_o), 1);
    chk({req, " first after drop"}, int'(first_strobe_o), 0);
    repeat (ack_c() - 1) @(negedge clk);
    chk({req, " da held"}, int'(da_o), a);
    chk({req, " cs held"}, int'(cs_n_o), c);
    chk({req, " busy held"}, int'(busy_o), 1);
    @(negedge clk);
    idle_chk({req, " back idle"});
  endtask

  // early_k < 0: no early edge
  task automatic burst(int m, int wait_c, int early_k, int valid_k, bit abort_b);
    int a, c, n, cnt;
    a = int'($urandom % (1 << AW));
    c = int'($urandom % (1 << CSW));
    @(negedge clk);
    start_i = 1'b1; mode_i = 3'(m); addr_i = AW'(a); cs_n_i = CSW'(c);
    @(negedge clk);
    start_i = 1'b0; mode_i = 3'($urandom % 6); addr_i = '0;
    chk("R2 busy", int'(busy_o), 1);
    chk("R2 da", int'(da_o), a);
    chk("R2 cs_n", int'(cs_n_o), c);
    for (int i = 0; i < wait_c; i++) begin
      dstrobe_i = ~dstrobe_i;
      @(negedge clk);
      if (dmack_n_o !== 1'b1) chk("R3 dmack_n while no request", int'(dmack_n_o), 1);
    end
    total++;
    chk("R7 err before ack", int'(err_o), 0);
    chk("R7 first before ack", int'(first_strobe_o), 0);
    dmarq_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (dmack_n_o && n < 50);
    chk("R4 ack delay", n, ack_c() + 1);
    chk("R5 dd_oe", int'(dd_oe_o), 0);
    chk("R2 da at ack", int'(da_o), a);
    cnt = 0;
    while (stop_o && cnt < 50) begin @(negedge clk); cnt++; end
    chk("R6 stop delay", cnt, env_c());
    chk("R6 within max", int'(cnt <= env_hi(m)), 1);
    chk("R6 hdmardy_n", int'(hdmardy_n_o), 0);
    if (abort_b) begin
      dmarq_i = 1'b0;
      @(negedge clk);
      hold_tail("R10", a, c);
      return;
    end
    if (early_k >= 0) begin
      while (cnt < early_k) begin @(negedge clk); cnt++; end
      dstrobe_i = ~dstrobe_i;
      @(negedge clk); cnt++;
      chk("R8 err", int'(err_o), 1);
      chk("R8 first", int'(first_strobe_o), 0);
    end
    while (cnt < valid_k) begin @(negedge clk); cnt++; end
    dstrobe_i = ~dstrobe_i;
    @(negedge clk);
    chk("R9 first", int'(first_strobe_o), 1);
    chk("R9 stop", int'(stop_o), 0);
    chk("R9 dmack_n", int'(dmack_n_o), 0);
    chk("R8 err sticky", int'(err_o), int'(early_k >= 0));
    release_i = 1'b1; dmarq_i = 1'b0;
    @(negedge clk);
    release_i = 1'b0;
    hold_tail("R11", a, c);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    idle_chk("R1 after reset");
    chk("R1 first", int'(first_strobe_o), 0);
    chk("R1 err", int'(err_o), 0);
    burst(0, 3, fs_c(0) - 1, fs_c(0), 1'b0);
    burst(5, 0, fs_c(5) - 1, fs_c(5), 1'b0);
    burst(3, 300, -1, fs_c(3), 1'b0);
    burst(2, 5, -1, 0, 1'b1);
    burst(4, 1, env_c(), fs_c(4) + 2, 1'b0);
    for (int r = 0; r < 30; r++) begin
      int m, ek;
      m = int'($urandom % 6);
      ek = ($urandom % 2 == 0) ? -1 : env_c() + int'($urandom % (fs_c(m) - env_c()));
      burst(m, int'($urandom % 8), ek, fs_c(m) + int'($urandom % 4), ($urandom % 5) == 0);
    end
    summary();
  end
endmodule